// File: doc/BRIEF.md
# Serial bit-reversal reorderer

This block takes a continuous stream of complex samples and reorders it, frame by frame, from bit-reversed order into natural order. Each frame holds N = 2^LOG2N samples, and one sample can enter per clock. The block does not store a whole frame in a ping-pong memory. It chains elementary exchange stages instead. Each stage swaps one pair of index bits: it holds some samples in a shift register, lets others bypass it, and recirculates the samples that have to move later.

A typical use is behind a decimation-in-frequency FFT whose output comes out bit-reversed. The first valid sample after reset is index 0 of a frame. Every frame after that must be contiguous, but idle cycles between frames are allowed. The output carries a valid flag and a marker on the first sample of each frame.

Top module: `bitrev_stream`

## Requirements
- R1: After reset, out_valid and out_start are low, and they stay low until the first input sample has travelled through the block.
- R2: Take the k-th valid output of a frame, counted from 0. It is the input sample of the same frame whose arrival index is k with its LOG2N index bits mirrored: bit i moves to position LOG2N-1-i, and bit 0 is the first-arriving sample's least significant position. out_re and out_im are both carried unchanged.
- R3: Every sample has the same fixed latency. It is the sum over the stages s = 0 .. floor(LOG2N/2)-1 of (2^(LOG2N-1-s) - 2^s), plus one cycle. For LOG2N = 10 this is 962 cycles from presentation at the input to appearance at the output.
- R4: out_start is high exactly on the first valid output of each frame, every N valid outputs, and never while out_valid is low.
- R5: Frames presented back to back with no idle cycles leave the block as an unbroken run of valid outputs.
- R6: Idle cycles between frames do not disturb the ordering or the content of later frames.
- R7: For odd LOG2N, the middle index bit keeps its position and only the outer bit pairs are mirrored.
- R8: The number of valid outputs equals the number of valid inputs once the pipeline has drained. No output appears without an earlier input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_re | input | DW | Input real part |
| in_im | input | DW | Input imaginary part |
| out_valid | output | 1 | Output sample present |
| out_start | output | 1 | First sample of an output frame |
| out_re | output | DW | Output real part |
| out_im | output | DW | Output imaginary part |
| | | | |

## Verification
On every cycle the assertions check three things. The frame marker must coincide with a valid output. It must fall exactly on each N-th valid output. No valid output may appear unless an input is still in flight. Only the bench scenarios can show the actual reordering of sample contents, the exact latency figure, the gap-free output for back-to-back frames, and correct behaviour after idle gaps between frames. They do this with a 1024-point configuration and an 8-point configuration, which has an odd bit count.

// File: rtl/bitrev_stream.sv
module bitrev_stream #(
  parameter int LOG2N = 10,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_re,
  input  logic [DW-1:0] in_im,
  output logic          out_valid,
  output logic          out_start,
  output logic [DW-1:0] out_re,
  output logic [DW-1:0] out_im
);
  localparam int NS = LOG2N / 2;
  localparam int WW = 2 * DW + 2;
  localparam int VB = WW - 2;
  localparam int SB = WW - 1;

  logic [LOG2N-1:0] head_cnt;
  logic [WW-1:0]    link [0:NS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        head_cnt <= '0;
    else if (in_valid) head_cnt <= head_cnt + 1'b1;

  assign link[0] = {in_valid && (head_cnt == '0), in_valid, in_im, in_re};

  // stage s mirrors index bit HI with bit LO
  for (genvar s = 0; s < NS; s++) begin : g_xchg
    localparam int HI    = LOG2N - 1 - s;
    localparam int LO    = s;
    localparam int DEPTH = (1 << HI) - (1 << LO);

    logic [LOG2N-1:0] cnt;
    logic [WW-1:0]    line [0:DEPTH-1];
    logic             swap;

    assign swap = link[s][VB] & cnt[HI] & ~cnt[LO];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= '0;
        for (int m = 0; m < DEPTH; m++) line[m] <= '0;
      end else begin
        if (link[s][VB]) cnt <= cnt + 1'b1;
        line[0] <= swap ? line[DEPTH-1] : link[s];
        for (int m = 1; m < DEPTH; m++) line[m] <= line[m-1];
      end

    assign link[s+1] = swap ? link[s] : line[DEPTH-1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_start <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= link[NS][VB];
      out_start <= link[NS][SB];
      out_re    <= link[NS][DW-1:0];
      out_im    <= link[NS][2*DW-1:DW];
    end
endmodule

// File: rtl/bitrev_stream_chk.sv
module bitrev_stream_chk #(
  parameter int LOG2N = 10
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic out_valid,
  input logic out_start
);
  logic [LOG2N-1:0] ocnt;
  logic [31:0]      pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ocnt <= '0;
      pend <= '0;
    end else begin
      if (out_valid) ocnt <= ocnt + 1'b1;
      pend <= pend + 32'(in_valid) - 32'(out_valid);
    end

  AST_START_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> out_valid); // R4
  AST_START_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_start) |-> (ocnt == '0)); // R4
  AST_BOUNDARY_HAS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ocnt == '0) |-> out_start); // R4
  AST_NO_OUTPUT_UNFED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pend != 32'd0)); // R8
endmodule

bind bitrev_stream bitrev_stream_chk #(.LOG2N(LOG2N)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_start(out_start)
);

// File: tb/tb_bitrev_stream.sv
`timescale 1ns/1ps
module tb_bitrev_stream;
  localparam int BLG = 10, BN = 1 << BLG, BDW = 16;
  localparam int SLG = 3,  SN = 1 << SLG, SDW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  bit running = 1'b0, b_done = 1'b0, s_done = 1'b0;

  logic b_iv = 1'b0, b_ov, b_os;
  logic [BDW-1:0] b_ire = '0, b_iim = '0, b_ore, b_oim;
  logic s_iv = 1'b0, s_ov, s_os;
  logic [SDW-1:0] s_ire = '0, s_iim = '0, s_ore, s_oim;

  bitrev_stream #(.LOG2N(BLG), .DW(BDW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(b_iv), .in_re(b_ire), .in_im(b_iim),
    .out_valid(b_ov), .out_start(b_os), .out_re(b_ore), .out_im(b_oim));

  bitrev_stream #(.LOG2N(SLG), .DW(SDW)) dut_small (
    .clk(clk), .rst_n(rst_n), .in_valid(s_iv), .in_re(s_ire), .in_im(s_iim),
    .out_valid(s_ov), .out_start(s_os), .out_re(s_ore), .out_im(s_oim));

  function automatic int rev(input int v, input int lg);
    int r = 0;
    for (int i = 0; i < lg; i++) if (v[i]) r |= 1 << (lg - 1 - i);
    return r;
  endfunction

  function automatic int lat(input int lg);
    int t = 1;
    for (int s = 0; s < lg / 2; s++) t += (1 << (lg - 1 - s)) - (1 << s);
    return t;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  int b_in = 0, b_out = 0, b_first_in = -1, b_first_out = -1;
  int s_in = 0, s_out = 0, s_first_in = -1;

  // 1024-point driver: frames 0-2 back to back, gaps before frames 3 and 4
  initial begin
    wait (running);
    for (int f = 0; f < 5; f++) begin
      int gap;
      gap = (f == 3) ? 7 : (f == 4) ? 1 : 0;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); b_iv = 1'b0;
      end
      for (int i = 0; i < BN; i++) begin
        @(negedge clk);
        if (b_first_in < 0) b_first_in = cyc;
        b_iv  = 1'b1;
        b_ire = BDW'(f * BN + i);
        b_iim = ~BDW'(f * BN + i);
        b_in++;
      end
    end
    @(negedge clk); b_iv = 1'b0;
    repeat (lat(BLG) + 10) @(negedge clk);
    b_done = 1'b1;
  end

  // 8-point driver, odd bit count: idle gaps of varying length between frames
  initial begin
    wait (running);
    for (int f = 0; f < 40; f++) begin
      if (f % 4 == 3)
        for (int g = 0; g < (f % 7) + 1; g++) begin
          @(negedge clk); s_iv = 1'b0;
        end
      for (int i = 0; i < SN; i++) begin
        @(negedge clk);
        if (s_first_in < 0) s_first_in = cyc;
        s_iv  = 1'b1;
        s_ire = SDW'(f * SN + i);
        s_iim = ~SDW'(f * SN + i);
        s_in++;
      end
    end
    @(negedge clk); s_iv = 1'b0;
    repeat (lat(SLG) + 10) @(negedge clk);
    s_done = 1'b1;
  end

  always @(negedge clk) if (running && b_ov) begin
    int p, f, e;
    string tag;
    p = b_out % BN;
    f = b_out / BN;
    e = f * BN + rev(p, BLG);
    tag = (f >= 3) ? "R6" : "R2";
    if (b_out == 0) begin
      b_first_out = cyc;
      check(cyc - b_first_in == lat(BLG), "R3", "first output latency",
            cyc - b_first_in, lat(BLG));
    end
    if (b_out < 3 * BN)
      check(cyc == b_first_out + b_out, "R5", "unbroken output run cycle",
            cyc, b_first_out + b_out);
    check(b_ore == BDW'(e) && b_oim == ~BDW'(e), tag, "1024-point sample",
          int'(b_ore), int'(BDW'(e)));
    check(b_os == (p == 0), "R4", "1024-point frame marker", int'(b_os), int'(p == 0));
    b_out++;
  end

  always @(negedge clk) if (running && s_ov) begin
    int p, f, e;
    p = s_out % SN;
    f = s_out / SN;
    e = f * SN + rev(p, SLG);
    if (s_out == 0)
      check(cyc - s_first_in == lat(SLG), "R3", "8-point latency",
            cyc - s_first_in, lat(SLG));
    check(s_ore == SDW'(e) && s_oim == ~SDW'(e), "R7", "8-point sample",
          int'(s_ore), int'(SDW'(e)));
    check(s_os == (p == 0), "R4", "8-point frame marker", int'(s_os), int'(p == 0));
    s_out++;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(!b_ov && !b_os && !s_ov && !s_os, "R1", "outputs during reset",
          int'(b_ov | b_os | s_ov | s_os), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!b_ov && !b_os && !s_ov && !s_os, "R1", "outputs after reset",
          int'(b_ov | b_os | s_ov | s_os), 0);
    running = 1'b1;
    wait (b_done && s_done);
    check(b_out == b_in, "R8", "1024-point output count", b_out, b_in);
    check(s_out == s_in, "R8", "8-point output count", s_out, s_in);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R8", "watchdog expired", cyc, 0);
    finish_run();
  end
endmodule